// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit turns a 16-bit offset into a 20-bit physical address. It holds four 16-bit segment registers (code, data, stack and extra) and picks one of them for each access. The physical address is the chosen segment value shifted left by four bit positions, plus the zero-extended offset. Any carry past the top address bit is dropped.

Each request carries three fields. The access kind says whether the request is an instruction fetch, an ordinary data access or the destination of a string operation. The base code names the register that supplied the offset. An optional override names a segment to use in place of the default. Instruction fetches always use the code segment, and string destinations always use the extra segment. Other accesses take the stack segment when the offset came from the frame pointer or the stack pointer, and the data segment otherwise. A valid override replaces that default for ordinary data accesses only.

Segment registers are loaded through a single write port. The result of each request is registered, so the address and the segment identifier appear one clock after the request together with a valid strobe.

Top module: `sag_addr_gen`

## Requirements
- R1: The physical address equals (segment << 4) + offset, taken modulo 2^20. For example, segment 16'h1230 with offset 16'h0045 gives 20'h12345, and segment 16'hFFFF with offset 16'h0010 gives 20'h00000.
- R2: When req_valid is high at a rising edge, addr_valid is high after that edge and phys_addr and seg_used carry that request's result. When req_valid is low at an edge, addr_valid goes low and phys_addr and seg_used keep their previous values.
- R3: For a data access with no valid override, base codes 0 (no base), 1 (base register), 2 (source index) and 3 (destination index) select the data segment. The segment identifiers are 0 code, 1 data, 2 stack and 3 extra.
- R4: For a data access with no valid override, base codes 4 (frame pointer) and 5 (stack pointer) select the stack segment.
- R5: Access kind 0 (instruction fetch) always selects the code segment, whatever the base code and the override inputs are.
- R6: Access kind 2 (string destination) always selects the extra segment, whatever the base code and the override inputs are.
- R7: For access kind 1 (data) and kind 3, a high ovr_valid replaces the default segment with the segment that ovr_sel names, using the same identifier encoding as R3.
- R8: When seg_wr_en is high at an edge, the register that seg_wr_sel names (encoding as in R3) is loaded with seg_wr_data. A request in that same cycle uses the old value, and requests in later cycles use the new one.
- R9: After reset, the code segment holds 16'hFFFF and the other three segments hold 0. addr_valid is 0, phys_addr is 0 and seg_used is 0.
- R10: Reserved base codes 6 and 7 act like code 0. Reserved access kind 3 acts like a data access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Load a segment register |
| seg_wr_sel | input | 2 | Segment register to load (0 code, 1 data, 2 stack, 3 extra) |
| seg_wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Address request present |
| req_kind | input | 2 | 0 fetch, 1 data, 2 string destination, 3 reserved (data) |
| req_base | input | 3 | Register that supplied the offset (see R3, R4, R10) |
| req_offset | input | 16 | Offset |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment identifier |
| addr_valid | output | 1 | Registered result valid |
| phys_addr | output | 20 | Physical address |
| seg_used | output | 2 | Identifier of the segment that was used |

## Verification
The bench goes after the wrap at the top of the address space. A design that keeps the carry or truncates in the wrong place returns 20'h100000-style values, or drops the high nibble of the segment. It checks that fetches and string destinations ignore an asserted override and a stack-type base code. A design that applies the override everywhere would report the wrong segment and address. It also issues a segment write and a request in the same cycle, and checks the reset value of the code segment through a fetch. A design with a write bypass, or with a zero reset on every segment, would return a different address.

// File: rtl/sag_pkg.sv
package sag_pkg;

    localparam int NUM_SEG = 4;
    localparam int SEG_SEL_W = $clog2(NUM_SEG);

    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_id_e;

    typedef enum logic [1:0] {
        ACC_FETCH  = 2'd0,
        ACC_DATA   = 2'd1,
        ACC_STRDST = 2'd2,
        ACC_RSVD   = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        BASE_NONE   = 3'd0,
        BASE_BASE   = 3'd1,
        BASE_SRCIDX = 3'd2,
        BASE_DSTIDX = 3'd3,
        BASE_FRAME  = 3'd4,
        BASE_STKPTR = 3'd5,
        BASE_RSV6   = 3'd6,
        BASE_RSV7   = 3'd7
    } base_code_e;

endpackage

// File: rtl/sag_segfile.sv
module sag_segfile #(
    parameter int SEG_W        = 16,
    parameter int NUM          = 4,
    parameter int RST_IDX      = 0,
    parameter logic [15:0] RST_VAL = 16'hFFFF
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [$clog2(NUM)-1:0]       wr_sel,
    input  logic [SEG_W-1:0]             wr_data,
    output logic [NUM-1:0][SEG_W-1:0]    seg_q
);

    localparam int SEL_W = $clog2(NUM);

    for (genvar i = 0; i < NUM; i++) begin : g_seg
        localparam logic [SEL_W-1:0] IDX = SEL_W'(i);
        localparam logic [SEG_W-1:0] INIT = (i == RST_IDX) ? SEG_W'(RST_VAL) : '0;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                seg_q[i] <= INIT;
            end else if (wr_en && (wr_sel == IDX)) begin
                seg_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/sag_seg_pick.sv
module sag_seg_pick
    import sag_pkg::*;
(
    input  acc_kind_e  kind,
    input  base_code_e base,
    input  logic       ovr_valid,
    input  seg_id_e    ovr_sel,
    output seg_id_e    seg_id
);

    seg_id_e dflt;

    always_comb begin
        unique case (base)
            BASE_FRAME, BASE_STKPTR: dflt = SEG_STACK;
            BASE_NONE, BASE_BASE, BASE_SRCIDX, BASE_DSTIDX,
            BASE_RSV6, BASE_RSV7:    dflt = SEG_DATA;
            default:                 dflt = SEG_DATA;
        endcase
    end

    always_comb begin
        unique case (kind)
            ACC_FETCH:          seg_id = SEG_CODE;
            ACC_STRDST:         seg_id = SEG_EXTRA;
            ACC_DATA, ACC_RSVD: seg_id = ovr_valid ? ovr_sel : dflt;
            default:            seg_id = SEG_DATA;
        endcase
    end

endmodule

// File: rtl/sag_shift_add.sv
module sag_shift_add #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] seg_sh;
    logic [ADDR_W-1:0] ofs_ext;

    assign seg_sh  = {seg, {SHIFT{1'b0}}};
    assign ofs_ext = {{(ADDR_W-OFS_W){1'b0}}, ofs};
    // carry past the top bit is dropped by the sum width
    assign addr    = seg_sh + ofs_ext;

endmodule

// File: rtl/sag_addr_gen.sv
module sag_addr_gen
    import sag_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter logic [15:0] CODE_RST = 16'hFFFF,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [1:0]        seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [2:0]        req_base,
    input  logic [OFS_W-1:0]  req_offset,
    input  logic              ovr_valid,
    input  logic [1:0]        ovr_sel,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] phys_addr,
    output logic [1:0]        seg_used
);

    logic [NUM_SEG-1:0][SEG_W-1:0] seg_regs;
    seg_id_e                       pick;
    logic [SEG_W-1:0]              seg_val;
    logic [ADDR_W-1:0]             sum;

    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;
    seg_id_e           id_q;

    sag_segfile #(
        .SEG_W   (SEG_W),
        .NUM     (NUM_SEG),
        .RST_IDX (int'(SEG_CODE)),
        .RST_VAL (CODE_RST)
    ) u_segs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .seg_q   (seg_regs)
    );

    sag_seg_pick u_pick (
        .kind      (acc_kind_e'(req_kind)),
        .base      (base_code_e'(req_base)),
        .ovr_valid (ovr_valid),
        .ovr_sel   (seg_id_e'(ovr_sel)),
        .seg_id    (pick)
    );

    assign seg_val = seg_regs[pick];

    sag_shift_add #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .SHIFT (SHIFT)
    ) u_add (
        .seg  (seg_val),
        .ofs  (req_offset),
        .addr (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            id_q   <= SEG_CODE;
        end else begin
            vld_q <= req_valid;
            if (req_valid) begin
                addr_q <= sum;
                id_q   <= pick;
            end
        end
    end

    always_comb begin
        addr_valid = vld_q;
        phys_addr  = addr_q;
        seg_used   = id_q;
    end

endmodule

// File: rtl/sag_addr_gen_chk.sv
module sag_addr_gen_chk #(
    parameter int ADDR_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic [2:0]        req_base,
    input logic              ovr_valid,
    input logic [1:0]        ovr_sel,
    input logic              addr_valid,
    input logic [ADDR_W-1:0] phys_addr,
    input logic [1:0]        seg_used
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> addr_valid); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!addr_valid && $stable(phys_addr) && $stable(seg_used))); // R2

    AST_STACK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd1 && !ovr_valid && (req_base == 3'd4 || req_base == 3'd5))
        |=> seg_used == 2'd2); // R4

    AST_FETCH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd0) |=> seg_used == 2'd0); // R5

    AST_STRDST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=> seg_used == 2'd3); // R6

    AST_OVR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind[0] && ovr_valid) |=> seg_used == $past(ovr_sel)); // R7

endmodule

bind sag_addr_gen sag_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_base   (req_base),
    .ovr_valid  (ovr_valid),
    .ovr_sel    (ovr_sel),
    .addr_valid (addr_valid),
    .phys_addr  (phys_addr),
    .seg_used   (seg_used)
);

// File: tb/tb_sag_addr_gen.sv
`timescale 1ns/1ps
module tb_sag_addr_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic [2:0]  req_base = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        addr_valid;
    logic [19:0] phys_addr;
    logic [1:0]  seg_used;

    int checks = 0;
    int bad = 0;
    bit done = 0;
    logic [15:0] mseg [4];

    always #2 clk = ~clk;

    sag_addr_gen dut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_kind(req_kind), .req_base(req_base),
        .req_offset(req_offset), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
        .addr_valid(addr_valid), .phys_addr(phys_addr), .seg_used(seg_used)
    );

    function automatic logic [19:0] ea(input logic [15:0] s, input logic [15:0] o);
        logic [20:0] full;
        full = {1'b0, s, 4'h0} + {5'h0, o};
        return full[19:0];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
        mseg[sel] = val;
    endtask

    task automatic req(input string tag, input logic [1:0] k, input logic [2:0] b,
                       input logic [15:0] o, input logic ov, input logic [1:0] os,
                       input logic [1:0] exp_seg);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_base = b; req_offset = o;
        ovr_valid = ov; ovr_sel = os;
        @(negedge clk);
        req_valid = 1'b0; ovr_valid = 1'b0;
        chk({tag, " valid"}, 32'(addr_valid), 32'd1);
        chk({tag, " seg"}, 32'(seg_used), 32'(exp_seg));
        chk({tag, " addr"}, 32'(phys_addr), 32'(ea(mseg[exp_seg], o)));
    endtask

    task automatic t_reset;
        chk("R9 valid", 32'(addr_valid), 32'd0);
        chk("R9 addr", 32'(phys_addr), 32'd0);
        chk("R9 seg", 32'(seg_used), 32'd0);
        req("R9 code reset fetch", 2'd0, 3'd0, 16'h0000, 1'b0, 2'd0, 2'd0);
        chk("R9 fetch FFFF0", 32'(phys_addr), 32'hFFFF0);
        req("R9 data reset zero", 2'd1, 3'd1, 16'h0042, 1'b0, 2'd0, 2'd1);
    endtask

    task automatic t_load;
        wr_seg(2'd0, 16'h4000);
        wr_seg(2'd1, 16'h1230);
        wr_seg(2'd2, 16'h2000);
        wr_seg(2'd3, 16'h3000);
        req("R8 code loaded", 2'd0, 3'd0, 16'h0000, 1'b0, 2'd0, 2'd0);
        req("R8 extra loaded", 2'd2, 3'd3, 16'h0000, 1'b0, 2'd0, 2'd3);
    endtask

    task automatic t_data_default;
        req("R1 R3 base", 2'd1, 3'd1, 16'h0045, 1'b0, 2'd0, 2'd1);
        chk("R1 12345", 32'(phys_addr), 32'h12345);
        req("R3 srcidx", 2'd1, 3'd2, 16'h0100, 1'b0, 2'd0, 2'd1);
        req("R3 dstidx", 2'd1, 3'd3, 16'h0010, 1'b0, 2'd0, 2'd1);
        req("R3 none", 2'd1, 3'd0, 16'h0002, 1'b0, 2'd0, 2'd1);
    endtask

    task automatic t_stack_default;
        req("R4 frame", 2'd1, 3'd4, 16'h0008, 1'b0, 2'd0, 2'd2);
        req("R4 stkptr", 2'd1, 3'd5, 16'hFFFE, 1'b0, 2'd0, 2'd2);
    endtask

    task automatic t_fixed;
        req("R5 fetch ignores ovr", 2'd0, 3'd4, 16'h0123, 1'b1, 2'd3, 2'd0);
        req("R6 strdst ignores ovr", 2'd2, 3'd5, 16'h0004, 1'b1, 2'd2, 2'd3);
    endtask

    task automatic t_override;
        req("R7 frame to extra", 2'd1, 3'd4, 16'h0008, 1'b1, 2'd3, 2'd3);
        req("R7 base to code", 2'd1, 3'd1, 16'h0001, 1'b1, 2'd0, 2'd0);
        req("R7 kind3 ovr stack", 2'd3, 3'd2, 16'h0020, 1'b1, 2'd2, 2'd2);
    endtask

    task automatic t_reserved;
        req("R10 base7", 2'd1, 3'd7, 16'h0000, 1'b0, 2'd0, 2'd1);
        req("R10 base6", 2'd1, 3'd6, 16'h0011, 1'b0, 2'd0, 2'd1);
        req("R10 kind3 frame", 2'd3, 3'd4, 16'h0005, 1'b0, 2'd0, 2'd2);
    endtask

    task automatic t_hold;
        logic [19:0] prev_a;
        logic [1:0]  prev_s;
        req("R2 setup", 2'd1, 3'd1, 16'h0777, 1'b0, 2'd0, 2'd1);
        prev_a = phys_addr; prev_s = seg_used;
        req_kind = 2'd2; req_offset = 16'h1111;
        @(negedge clk);
        chk("R2 idle valid", 32'(addr_valid), 32'd0);
        chk("R2 idle addr", 32'(phys_addr), 32'(prev_a));
        chk("R2 idle seg", 32'(seg_used), 32'(prev_s));
    endtask

    task automatic t_same_cycle;
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = 2'd1; seg_wr_data = 16'h5555;
        req_valid = 1'b1; req_kind = 2'd1; req_base = 3'd1; req_offset = 16'h0000;
        ovr_valid = 1'b0;
        @(negedge clk);
        seg_wr_en = 1'b0; req_valid = 1'b0;
        chk("R8 same cycle old", 32'(phys_addr), 32'h12300);
        mseg[1] = 16'h5555;
        req("R8 next new", 2'd1, 3'd1, 16'h0000, 1'b0, 2'd0, 2'd1);
        chk("R8 55550", 32'(phys_addr), 32'h55550);
    endtask

    task automatic t_wrap;
        wr_seg(2'd1, 16'hFFFF);
        req("R1 wrap zero", 2'd1, 3'd1, 16'h0010, 1'b0, 2'd0, 2'd1);
        chk("R1 wrap 00000", 32'(phys_addr), 32'h00000);
        req("R1 wrap FFEF", 2'd1, 3'd2, 16'hFFFF, 1'b0, 2'd0, 2'd1);
        chk("R1 wrap 0FFEF", 32'(phys_addr), 32'h0FFEF);
    endtask

    initial begin
        mseg[0] = 16'hFFFF; mseg[1] = 16'h0; mseg[2] = 16'h0; mseg[3] = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_data_default();
        t_stack_default();
        t_fixed();
        t_override();
        t_reserved();
        t_hold();
        t_same_cycle();
        t_wrap();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule